// File: doc/BRIEF.md
# Glitch-free clock power-down sequencer

This block sits between the free-running clock sources of a multi-output clock generator and its output pins. When an active-high power-down request arrives, asynchronous to every clock, the block qualifies it against the CPU complement clock. It then parks every output at a defined level. Each clock stops on its own falling edge, so that no shortened pulse reaches a pin. Once every output has parked, the block drops the oscillator enable.

When the request is removed, the oscillator enable comes back first. After a fixed settling count of CPU cycles, the block ungates each output on that output's own falling edge, and every clock resumes with full-width pulses. Differential pairs are handled by index, with pair 0 being the CPU pair whose complement leg clocks the control logic. Each pair has a mode bit that selects how it parks. With the bit at 0, the true leg is driven high and the complement leg is released. With the bit at 1, both legs are released. Output-enable pins model the released, tri-stated state.

Top module: `clkpd_seq`

## Requirements
- R1: A stop begins only if `pdReq` is sampled high on two consecutive rising edges of `pairClkC[0]`. A request that covers at most one such edge stops no clock and leaves `oscEn` high. The complement leg of pair 0 parks on the falling edge of `pairClkC[0]` that follows the second of those rising edges, and not before it.
- R2: Each single-ended output `seOut[i]` parks low, and this starts at a falling edge of `seClk[i]`. No high or low pulse on any output is shorter than half the period of its source.
- R3: Each differential pair stops on a falling edge of its complement input. While stopped, `pairOutC` is 0 and `pairOeC` is 0 (complement undriven).
- R4: With `pairMode[i]`=0, a stopped pair drives `pairOutT[i]`=1 with `pairOeT[i]`=1.
- R5: With `pairMode[i]`=1, a stopped pair has `pairOeT[i]`=0 and `pairOeC[i]`=0.
- R6: `oscEn` goes low only when every output has parked. While `oscEn` is low, all outputs stay parked.
- R7: On release, `oscEn` rises on the second `pairClkC[0]` rising edge that samples `pdReq` low. All outputs stay parked for at least 4 further rising edges of `pairClkC[0]`.
- R8: After the settling count, each output is ungated on its own falling edge and resumes without a runt. Pair 0's complement is re-enabled on the first falling edge of `pairClkC[0]` after the 4th settling edge.
- R9: Reset state is: `oscEn`=1, all output enables 1, and all outputs following their source clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rstN | input | 1 | Asynchronous active-low reset |
| pdReq | input | 1 | Asynchronous active-high power-down request |
| pairMode | input | NUM_PAIR | Park mode per pair: 0 true-high, 1 both legs undriven |
| pairClkT | input | NUM_PAIR | True leg of each differential source (index 0 = CPU) |
| pairClkC | input | NUM_PAIR | Complement leg of each differential source |
| seClk | input | NUM_SE | Single-ended source clocks |
| pairOutT | output | NUM_PAIR | Gated true legs |
| pairOutC | output | NUM_PAIR | Gated complement legs |
| pairOeT | output | NUM_PAIR | Output enable of true legs |
| pairOeC | output | NUM_PAIR | Output enable of complement legs |
| seOut | output | NUM_SE | Gated single-ended clocks |
| oscEn | output | 1 | Oscillator enable |

## Verification
The control sequence is tied to `pairClkC[0]` rising edges, so the CPU-pair checks are placed a precise number of edges after a stimulus. They run 2 ns after the second qualifying edge (still running), 1 ns after the following complement falling edge (parked), 2 ns after each of the two release edges (oscillator enable low, then high), and after each of the 4 settling edges (still parked), then 1 ns after the next falling edge (re-enabled). Clocks in other domains are not checked at an exact edge, because their timing relative to the CPU clock varies. Their parked levels are sampled only after 30 or more CPU cycles, and pulse widths are measured on every edge of every output against half the source period.

// File: rtl/clkpd_pkg.sv
package clkpd_pkg;

  typedef enum logic [2:0] {
    ST_RUN,
    ST_GATE,
    ST_OFF,
    ST_SETTLE,
    ST_UNGATE
  } pdState_t;

  typedef struct packed {
    logic gateReq;
    logic oscEn;
  } ctlStrobe_t;

endpackage

// File: rtl/clkpd_ctrl.sv
module clkpd_ctrl
  import clkpd_pkg::*;
#(
  parameter int SETTLE_CYC = 4
) (
  input  logic       ctlClk,
  input  logic       rstN,
  input  logic       pdReq,
  input  logic       allParked,
  input  logic       anyParked,
  output ctlStrobe_t strobe
);

  localparam int CW = $clog2(SETTLE_CYC + 1);

  pdState_t      state, nxtState;
  logic          seenHi;
  logic          reqHi, reqLo;
  logic [1:0]    allSync, anySync;
  logic [CW-1:0] settleCnt;

  assign reqHi = pdReq & seenHi;
  assign reqLo = ~pdReq & ~seenHi;

  always_ff @(posedge ctlClk or negedge rstN) begin
    if (!rstN) begin
      seenHi  <= 1'b0;
      allSync <= '0;
      anySync <= '0;
    end else begin
      seenHi  <= pdReq;
      allSync <= {allSync[0], allParked};
      anySync <= {anySync[0], anyParked};
    end
  end

  always_comb begin
    nxtState = state;
    unique case (state)
      ST_RUN:    if (reqHi) nxtState = ST_GATE;
      ST_GATE:   if (allSync[1]) nxtState = ST_OFF;
      ST_OFF:    if (reqLo) nxtState = ST_SETTLE;
      ST_SETTLE: if (settleCnt == CW'(SETTLE_CYC - 1)) nxtState = ST_UNGATE;
      ST_UNGATE: if (!anySync[1]) nxtState = ST_RUN;
      default:   nxtState = ST_RUN;
    endcase
  end

  always_ff @(posedge ctlClk or negedge rstN) begin
    if (!rstN) begin
      state          <= ST_RUN;
      settleCnt      <= '0;
      strobe.gateReq <= 1'b0;
      strobe.oscEn   <= 1'b1;
    end else begin
      state          <= nxtState;
      settleCnt      <= (state == ST_SETTLE) ? settleCnt + 1'b1 : '0;
      strobe.gateReq <= (nxtState == ST_GATE) || (nxtState == ST_OFF) ||
                        (nxtState == ST_SETTLE);
      strobe.oscEn   <= (nxtState != ST_OFF);
    end
  end

endmodule

// File: rtl/clkpd_path.sv
module clkpd_path
  import clkpd_pkg::*;
#(
  parameter int NUM_PAIR = 2,
  parameter int NUM_SE   = 3
) (
  input  logic                rstN,
  input  ctlStrobe_t          strobe,
  input  logic [NUM_PAIR-1:0] pairMode,
  input  logic [NUM_PAIR-1:0] pairClkT,
  input  logic [NUM_PAIR-1:0] pairClkC,
  input  logic [NUM_SE-1:0]   seClk,
  output logic [NUM_PAIR-1:0] pairOutT,
  output logic [NUM_PAIR-1:0] pairOutC,
  output logic [NUM_PAIR-1:0] pairOeT,
  output logic [NUM_PAIR-1:0] pairOeC,
  output logic [NUM_SE-1:0]   seOut,
  output logic                allParked,
  output logic                anyParked
);

  localparam int NUM_OUT = NUM_PAIR + NUM_SE;

  logic [NUM_OUT-1:0] parked;

  // Differential pairs: enable flop on the complement falling edge, where the
  // true leg has just risen and the complement has just fallen.
  for (genvar g = 0; g < NUM_PAIR; g++) begin : g_pair
    logic stopQ;
    always_ff @(negedge pairClkC[g] or negedge rstN) begin
      if (!rstN) stopQ <= 1'b0;
      else       stopQ <= strobe.gateReq;
    end
    assign pairOutT[g] = pairClkT[g] | stopQ;
    assign pairOutC[g] = pairClkC[g] & ~stopQ;
    assign pairOeC[g]  = ~stopQ;
    assign pairOeT[g]  = ~(stopQ & pairMode[g]);
    assign parked[g]   = stopQ;
  end

  // Single-ended clocks: enable flop on the clock's own falling edge, so the
  // enable only changes while the clock is low.
  for (genvar g = 0; g < NUM_SE; g++) begin : g_se
    logic stopQ;
    always_ff @(negedge seClk[g] or negedge rstN) begin
      if (!rstN) stopQ <= 1'b0;
      else       stopQ <= strobe.gateReq;
    end
    assign seOut[g]             = seClk[g] & ~stopQ;
    assign parked[NUM_PAIR + g] = stopQ;
  end

  assign allParked = &parked;
  assign anyParked = |parked;

endmodule

// File: rtl/clkpd_seq.sv
module clkpd_seq
  import clkpd_pkg::*;
#(
  parameter int NUM_PAIR   = 2,
  parameter int NUM_SE     = 3,
  parameter int SETTLE_CYC = 4
) (
  input  logic                rstN,
  input  logic                pdReq,
  input  logic [NUM_PAIR-1:0] pairMode,
  input  logic [NUM_PAIR-1:0] pairClkT,
  input  logic [NUM_PAIR-1:0] pairClkC,
  input  logic [NUM_SE-1:0]   seClk,
  output logic [NUM_PAIR-1:0] pairOutT,
  output logic [NUM_PAIR-1:0] pairOutC,
  output logic [NUM_PAIR-1:0] pairOeT,
  output logic [NUM_PAIR-1:0] pairOeC,
  output logic [NUM_SE-1:0]   seOut,
  output logic                oscEn
);

  ctlStrobe_t strobe;
  logic       allParked;
  logic       anyParked;

  clkpd_ctrl #(.SETTLE_CYC(SETTLE_CYC)) u_ctrl (
    .ctlClk    (pairClkC[0]),
    .rstN      (rstN),
    .pdReq     (pdReq),
    .allParked (allParked),
    .anyParked (anyParked),
    .strobe    (strobe)
  );

  clkpd_path #(.NUM_PAIR(NUM_PAIR), .NUM_SE(NUM_SE)) u_path (
    .rstN      (rstN),
    .strobe    (strobe),
    .pairMode  (pairMode),
    .pairClkT  (pairClkT),
    .pairClkC  (pairClkC),
    .seClk     (seClk),
    .pairOutT  (pairOutT),
    .pairOutC  (pairOutC),
    .pairOeT   (pairOeT),
    .pairOeC   (pairOeC),
    .seOut     (seOut),
    .allParked (allParked),
    .anyParked (anyParked)
  );

  assign oscEn = strobe.oscEn;

endmodule

// File: rtl/clkpd_chk.sv
module clkpd_chk #(
  parameter int NUM_PAIR = 2
) (
  input logic                ctlClk,
  input logic                rstN,
  input logic                pdReq,
  input logic                gateReq,
  input logic                oscEn,
  input logic                allParked,
  input logic [NUM_PAIR-1:0] pairMode,
  input logic [NUM_PAIR-1:0] pairOutT,
  input logic [NUM_PAIR-1:0] pairOeT,
  input logic [NUM_PAIR-1:0] pairOeC
);

  // R1
  gate_qual_chk: assert property (@(posedge ctlClk) disable iff (!rstN)
    $rose(gateReq) |-> ($past(pdReq) && $past(pdReq, 2)));

  // R3
  pair_stop_req_chk: assert property (@(posedge ctlClk) disable iff (!rstN)
    $fell(pairOeC[0]) |-> gateReq);

  // R4
  true_high_chk: assert property (@(posedge ctlClk) disable iff (!rstN)
    (!pairOeC[0] && !pairMode[0]) |-> (pairOutT[0] && pairOeT[0]));

  // R6
  osc_off_chk: assert property (@(posedge ctlClk) disable iff (!rstN)
    !oscEn |-> allParked);

  // R7
  wake_order_chk: assert property (@(posedge ctlClk) disable iff (!rstN)
    $rose(oscEn) |-> gateReq);

  // R8
  resume_chk: assert property (@(posedge ctlClk) disable iff (!rstN)
    $rose(pairOeC[0]) |-> !gateReq);

endmodule

bind clkpd_seq clkpd_chk #(.NUM_PAIR(NUM_PAIR)) u_chk (
  .ctlClk    (pairClkC[0]),
  .rstN      (rstN),
  .pdReq     (pdReq),
  .gateReq   (strobe.gateReq),
  .oscEn     (oscEn),
  .allParked (allParked),
  .pairMode  (pairMode),
  .pairOutT  (pairOutT),
  .pairOeT   (pairOeT),
  .pairOeC   (pairOeC)
);

// File: tb/sim_clkpd_seq.sv
`timescale 1ns/1ps
module sim_clkpd_seq;

  logic       rstN = 1'b0;
  logic       pdReq = 1'b0;
  logic [1:0] pairMode = 2'b00;
  logic [1:0] pairClkT = 2'b00;
  logic [1:0] pairClkC;
  logic [2:0] seClk = 3'b000;
  logic [1:0] pairOutT, pairOutC, pairOeT, pairOeC;
  logic [2:0] seOut;
  logic       oscEn;

  int nChk = 0, nBad = 0, runts = 0, oscFalls = 0;
  int seRise [3];

  always #10 pairClkT[0] = ~pairClkT[0];   // CPU pair, 50 MHz
  always #15 pairClkT[1] = ~pairClkT[1];
  always #7  seClk[0]    = ~seClk[0];
  always #13 seClk[1]    = ~seClk[1];
  always #23 seClk[2]    = ~seClk[2];
  assign pairClkC = ~pairClkT;

  clkpd_seq u0 (
    .rstN(rstN), .pdReq(pdReq), .pairMode(pairMode),
    .pairClkT(pairClkT), .pairClkC(pairClkC), .seClk(seClk),
    .pairOutT(pairOutT), .pairOutC(pairOutC), .pairOeT(pairOeT),
    .pairOeC(pairOeC), .seOut(seOut), .oscEn(oscEn)
  );

  function automatic real pairHalf(int i);
    return (i == 0) ? 10.0 : 15.0;
  endfunction
  function automatic real seHalf(int i);
    return (i == 0) ? 7.0 : (i == 1) ? 13.0 : 23.0;
  endfunction
  // Parked-state expectations: true OE low only in mode 1; true leg high in mode 0.
  function automatic logic [1:0] expOeT(logic [1:0] m);
    return ~m;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chkParked(input string req);
    chk(oscEn == 1'b0, {req, " R6 oscEn"}, oscEn, 0);
    chk(pairOeC == 2'b00, {req, " R3 oeC"}, pairOeC, 0);
    chk(pairOeT == expOeT(pairMode), {req, " R4/R5 oeT"}, pairOeT, expOeT(pairMode));
    chk((pairOutT | pairMode) == 2'b11, {req, " R4 outT"}, pairOutT | pairMode, 3);
    chk(seOut == 3'b000, {req, " R2 seOut"}, seOut, 0);
  endtask

  task automatic chkRunning(input string req);
    chk(oscEn == 1'b1, {req, " oscEn"}, oscEn, 1);
    chk(pairOeC == 2'b11 && pairOeT == 2'b11, {req, " oe"}, {pairOeT, pairOeC}, 15);
  endtask

  // Runt monitor on every output edge (R2, R8).
  for (genvar i = 0; i < 2; i++) begin : g_pmon
    realtime lastT = -1000.0;
    realtime lastC = -1000.0;
    always @(pairOutT[i]) begin
      if (rstN && ($realtime - lastT) < pairHalf(i) - 0.5) runts++;
      lastT = $realtime;
    end
    always @(pairOutC[i]) begin
      if (rstN && ($realtime - lastC) < pairHalf(i) - 0.5) runts++;
      lastC = $realtime;
    end
  end
  for (genvar i = 0; i < 3; i++) begin : g_smon
    realtime lastS = -1000.0;
    always @(seOut[i]) begin
      if (rstN && ($realtime - lastS) < seHalf(i) - 0.5) runts++;
      lastS = $realtime;
    end
    always @(posedge seOut[i]) seRise[i]++;
  end

  // R6: at every oscillator-enable fall, all outputs are already parked.
  always @(negedge oscEn) begin
    if (rstN) begin
      oscFalls++;
      chk(seOut == 3'b000 && pairOeC == 2'b00, "R6 osc fall before park",
          {seOut, pairOeC}, 0);
    end
  end

  initial begin
    #4_000_000;
    nBad++;
    nChk++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    int r0;
    void'($urandom(32'h5EED));
    #55 rstN = 1'b1;
    repeat (5) @(posedge pairClkC[0]);
    #2;
    // R9 reset state
    chkRunning("R9");
    r0 = seRise[0] + seRise[1] + seRise[2];
    repeat (10) @(posedge pairClkC[0]);
    #2;
    chk((seRise[0] + seRise[1] + seRise[2]) > r0 + 10, "R9 clocks toggle",
        seRise[0] + seRise[1] + seRise[2], r0 + 10);

    // R1: pulse between edges, then pulse covering exactly one edge
    @(posedge pairClkC[0]); #3 pdReq = 1'b1; #10 pdReq = 1'b0;
    @(posedge pairClkC[0]); #4 pdReq = 1'b1;
    @(posedge pairClkC[0]); #4 pdReq = 1'b0;
    repeat (20) @(posedge pairClkC[0]);
    #2;
    chk(oscFalls == 0, "R1 short request ignored", oscFalls, 0);
    chkRunning("R1");

    // R1/R3/R4/R5 exact CPU-pair stop timing
    pairMode = 2'($urandom);
    @(posedge pairClkC[0]); #2 pdReq = 1'b1;
    @(posedge pairClkC[0]);
    @(posedge pairClkC[0]);
    #2 chk(pairOeC[0] == 1'b1, "R1 not stopped before falling edge", pairOeC[0], 1);
    @(negedge pairClkC[0]);
    #1 chk(pairOeC[0] == 1'b0 && pairOutC[0] == 1'b0, "R3 cpu pair stopped",
           {pairOeC[0], pairOutC[0]}, 0);
    chk(pairOeT[0] == ~pairMode[0], "R4/R5 cpu true enable", pairOeT[0], ~pairMode[0]);
    repeat (30) @(posedge pairClkC[0]);
    #2 chkParked("park");

    // R7/R8 release timing
    @(posedge pairClkC[0]); #2 pdReq = 1'b0;
    @(posedge pairClkC[0]); #2 chk(oscEn == 1'b0, "R7 osc still off", oscEn, 0);
    @(posedge pairClkC[0]); #2 chk(oscEn == 1'b1, "R7 osc back", oscEn, 1);
    repeat (3) @(posedge pairClkC[0]);
    #2 chk(pairOeC == 2'b00 && seOut == 3'b000, "R7 held during settle",
           {pairOeC, seOut}, 0);
    @(posedge pairClkC[0]);
    #2 chk(pairOeC[0] == 1'b0, "R7 held at 4th edge", pairOeC[0], 0);
    @(negedge pairClkC[0]);
    #1 chk(pairOeC[0] == 1'b1, "R8 cpu pair resumes", pairOeC[0], 1);
    repeat (20) @(posedge pairClkC[0]);
    #2 chkRunning("R8");

    // Random mix of short and long requests
    for (int it = 0; it < 24; it++) begin
      int f0;
      pairMode = 2'($urandom);
      f0 = oscFalls;
      @(posedge pairClkC[0]);
      #(1 + $urandom % 8) pdReq = 1'b1;
      if (($urandom % 2) == 0) begin
        if (($urandom % 2) == 0) #(1 + $urandom % 8) pdReq = 1'b0;
        else begin
          @(posedge pairClkC[0]);
          #(1 + $urandom % 8) pdReq = 1'b0;
        end
        repeat (20) @(posedge pairClkC[0]);
        #2 chk(oscFalls == f0, "R1 random short ignored", oscFalls, f0);
        chkRunning("R1 random");
      end else begin
        repeat (30 + $urandom % 30) @(posedge pairClkC[0]);
        #2 chkParked("random");
        @(posedge pairClkC[0]);
        #(1 + $urandom % 8) pdReq = 1'b0;
        repeat (40) @(posedge pairClkC[0]);
        #2 chkRunning("R8 random");
      end
    end

    chk(runts == 0, "R2/R8 runt pulses", runts, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

endmodule